// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block holds the two doorbell interrupt flags of a memory that is shared by two ports. Each port runs on its own clock. On each port the block sees a chip enable, a read/write select and the internal address after the port's address counter. A write from one port to that port's outgoing mailbox location lowers the active-low interrupt of the other port. The interrupted port lowers nothing itself. It releases its own flag by reading its incoming mailbox location. With an address width of W bits, the right port's mailbox is the all-ones address and the left port's mailbox is the all-ones address minus one. A narrower address width therefore moves both mailboxes down to the top of the smaller space.

A flag register always lives in the clock domain of the port that reads it. A release is a purely local event. A doorbell arrives from the other domain as a toggle that passes through a synchronizer chain. The toggle is acknowledged back to the sender through a second toggle chain. If the sender rings again while an earlier ring is still unacknowledged, the block remembers that ring and sends it once the acknowledge returns. No ring is lost.

Top module: `mbx_doorbell`

## Requirements
- R1: While a port's reset is high, that port's interrupt output (`l_irq_n` or `r_irq_n`) goes high on its next clock edge. After reset, both outputs read 1 (no interrupt).
- R2: An enabled left-port write (`l_en`=1, `l_wr`=1) to address all-ones drives `r_irq_n` low. This happens within a bounded number of right-clock cycles, and the output stays low until it is released.
- R3: An enabled right-port read (`r_en`=1, `r_wr`=0) of address all-ones drives `r_irq_n` high on the next right-clock edge, unless a doorbell lands on that same edge.
- R4: An enabled right-port write to address all-ones minus one drives `l_irq_n` low within a bounded number of left-clock cycles.
- R5: An enabled left-port read of address all-ones minus one drives `l_irq_n` high on the next left-clock edge, unless a doorbell lands on that same edge.
- R6: An access with the enable low (`l_en`=0 or `r_en`=0) changes neither interrupt output, whatever the address and direction.
- R7: Any other enabled access leaves both outputs unchanged. This covers any access to a non-mailbox address, a read of the other port's mailbox, and a write to a port's own mailbox.
- R8: When a doorbell and a release reach the same flag on the same clock edge, the flag ends that edge low.
- R9: A doorbell written while an earlier doorbell from the same port is still unacknowledged is not lost. If the receiver releases the flag between the two doorbells, the flag is lowered again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_l | input | 1 | Left port clock |
| rst_l | input | 1 | Left domain reset, synchronous, active high |
| l_en | input | 1 | Left access enable, active high |
| l_wr | input | 1 | Left direction: 1 = write, 0 = read |
| l_addr | input | ADDR_W | Left internal (post-counter) address |
| l_irq_n | output | 1 | Left interrupt, active low |
| clk_r | input | 1 | Right port clock |
| rst_r | input | 1 | Right domain reset, synchronous, active high |
| r_en | input | 1 | Right access enable, active high |
| r_wr | input | 1 | Right direction: 1 = write, 0 = read |
| r_addr | input | ADDR_W | Right internal (post-counter) address |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
On every clock edge of each domain, the assertions check the behaviour that stays inside that domain. A received doorbell always lowers the flag, even against a simultaneous release. A lone release of the own mailbox raises the flag. A flag never falls without a received doorbell and never rises without a release read or a reset. The end-to-end path from one port's access to the other port's output crosses an asynchronous boundary, so only the bench scenarios show it. That path includes the enable and address filtering, the latency of the crossing, and the retention of a doorbell rung while an earlier one is in flight. The bench shows it by settling after each access and comparing both outputs with a reference model.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

    typedef struct packed {
        logic ring_peer;
        logic release_own;
    } port_evt_t;

    localparam int SIDE_L = 0;
    localparam int SIDE_R = 1;

    function automatic acc_kind_e classify(input logic en, input logic wr);
        if (!en)
            return ACC_NONE;
        return wr ? ACC_WRITE : ACC_READ;
    endfunction

endpackage

// File: rtl/mbx_bit_sync.sv
module mbx_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst)
            chain <= '0;
        else
            chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int SIDE   = SIDE_L
) (
    input  logic              en,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output port_evt_t         evt
);
    localparam logic [ADDR_W-1:0] TOP_ADDR  = '1;
    localparam logic [ADDR_W-1:0] NEXT_ADDR = TOP_ADDR - 1'b1;
    localparam logic [ADDR_W-1:0] OWN_BOX   = (SIDE == SIDE_R) ? TOP_ADDR : NEXT_ADDR;
    localparam logic [ADDR_W-1:0] PEER_BOX  = (SIDE == SIDE_R) ? NEXT_ADDR : TOP_ADDR;

    acc_kind_e kind;

    always_comb begin
        kind            = classify(en, wr);
        evt.ring_peer   = (kind == ACC_WRITE) && (addr == PEER_BOX);
        evt.release_own = (kind == ACC_READ)  && (addr == OWN_BOX);
    end
endmodule

// File: rtl/mbx_ring_tx.sv
module mbx_ring_tx #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ring,
    input  logic ack_tgl_async,
    output logic req_tgl
);
    logic ack_seen;
    logic again;
    logic busy;

    mbx_bit_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (ack_tgl_async),
        .dout (ack_seen)
    );

    assign busy = req_tgl ^ ack_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_tgl <= 1'b0;
            again   <= 1'b0;
        end else if (!busy && (ring || again)) begin
            req_tgl <= ~req_tgl;
            again   <= 1'b0;
        end else if (ring) begin
            again   <= 1'b1;
        end
    end
endmodule

// File: rtl/mbx_ring_rx.sv
module mbx_ring_rx #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req_tgl_async,
    output logic set_pulse,
    output logic ack_tgl
);
    logic req_seen;

    mbx_bit_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (req_tgl_async),
        .dout (req_seen)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ack_tgl <= 1'b0;
        else
            ack_tgl <= req_seen;
    end

    assign set_pulse = req_seen ^ ack_tgl;
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr_evt,
    output logic irq_n
);
    always_ff @(posedge clk) begin
        if (rst)
            irq_n <= 1'b1;
        else if (set_evt)
            irq_n <= 1'b0;
        else if (clr_evt)
            irq_n <= 1'b1;
    end
endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell
    import mbx_pkg::*;
#(
    parameter int ADDR_W      = 18,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_l,
    input  logic              rst_l,
    input  logic              l_en,
    input  logic              l_wr,
    input  logic [ADDR_W-1:0] l_addr,
    output logic              l_irq_n,
    input  logic              clk_r,
    input  logic              rst_r,
    input  logic              r_en,
    input  logic              r_wr,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              r_irq_n
);
    localparam int NSIDE = 2;

    logic [NSIDE-1:0]       clk_v;
    logic [NSIDE-1:0]       rst_v;
    logic [NSIDE-1:0]       en_v;
    logic [NSIDE-1:0]       wr_v;
    logic [ADDR_W-1:0]      addr_v [NSIDE];
    logic [NSIDE-1:0]       irq_v;
    logic [NSIDE-1:0]       req_v;
    logic [NSIDE-1:0]       ack_v;
    logic [NSIDE-1:0]       set_v;
    port_evt_t              evt_v  [NSIDE];

    logic l_set_evt;
    logic r_set_evt;

    assign clk_v = {clk_r, clk_l};
    assign rst_v = {rst_r, rst_l};
    assign en_v  = {r_en, l_en};
    assign wr_v  = {r_wr, l_wr};
    assign addr_v[SIDE_L] = l_addr;
    assign addr_v[SIDE_R] = r_addr;

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        mbx_port_decode #(.ADDR_W(ADDR_W), .SIDE(g)) u_dec (
            .en   (en_v[g]),
            .wr   (wr_v[g]),
            .addr (addr_v[g]),
            .evt  (evt_v[g])
        );

        mbx_ring_tx #(.SYNC_STAGES(SYNC_STAGES)) u_tx (
            .clk           (clk_v[g]),
            .rst           (rst_v[g]),
            .ring          (evt_v[g].ring_peer),
            .ack_tgl_async (ack_v[NSIDE-1-g]),
            .req_tgl       (req_v[g])
        );

        mbx_ring_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
            .clk           (clk_v[g]),
            .rst           (rst_v[g]),
            .req_tgl_async (req_v[NSIDE-1-g]),
            .set_pulse     (set_v[g]),
            .ack_tgl       (ack_v[g])
        );

        mbx_flag u_flag (
            .clk     (clk_v[g]),
            .rst     (rst_v[g]),
            .set_evt (set_v[g]),
            .clr_evt (evt_v[g].release_own),
            .irq_n   (irq_v[g])
        );
    end

    assign l_set_evt = set_v[SIDE_L];
    assign r_set_evt = set_v[SIDE_R];
    assign l_irq_n   = irq_v[SIDE_L];
    assign r_irq_n   = irq_v[SIDE_R];
endmodule

// File: rtl/mbx_irq_checker.sv
module mbx_irq_checker #(
    parameter int ADDR_W = 18
) (
    input logic              clk_l,
    input logic              rst_l,
    input logic              l_en,
    input logic              l_wr,
    input logic [ADDR_W-1:0] l_addr,
    input logic              l_irq_n,
    input logic              l_set_evt,
    input logic              clk_r,
    input logic              rst_r,
    input logic              r_en,
    input logic              r_wr,
    input logic [ADDR_W-1:0] r_addr,
    input logic              r_irq_n,
    input logic              r_set_evt
);
    localparam logic [ADDR_W-1:0] TOP_ADDR  = '1;
    localparam logic [ADDR_W-1:0] NEXT_ADDR = TOP_ADDR - 1'b1;

    logic l_release;
    logic r_release;
    assign l_release = l_en && !l_wr && (l_addr == NEXT_ADDR);
    assign r_release = r_en && !r_wr && (r_addr == TOP_ADDR);

    assert_reset_idle_l_R1: assert property (@(posedge clk_l) rst_l |=> l_irq_n);
    assert_reset_idle_r_R1: assert property (@(posedge clk_r) rst_r |=> r_irq_n);

    assert_ring_lowers_r_R2: assert property (@(posedge clk_r) disable iff (rst_r)
        r_set_evt |=> !r_irq_n);
    assert_ring_lowers_l_R4: assert property (@(posedge clk_l) disable iff (rst_l)
        l_set_evt |=> !l_irq_n);

    assert_release_raises_r_R3: assert property (@(posedge clk_r) disable iff (rst_r)
        (r_release && !r_set_evt) |=> r_irq_n);
    assert_release_raises_l_R5: assert property (@(posedge clk_l) disable iff (rst_l)
        (l_release && !l_set_evt) |=> l_irq_n);

    assert_set_beats_clear_r_R8: assert property (@(posedge clk_r) disable iff (rst_r)
        (r_set_evt && r_release) |=> !r_irq_n);
    assert_set_beats_clear_l_R8: assert property (@(posedge clk_l) disable iff (rst_l)
        (l_set_evt && l_release) |=> !l_irq_n);

    assert_fall_needs_ring_r_R7: assert property (@(posedge clk_r) disable iff (rst_r)
        $fell(r_irq_n) |-> $past(r_set_evt));
    assert_fall_needs_ring_l_R7: assert property (@(posedge clk_l) disable iff (rst_l)
        $fell(l_irq_n) |-> $past(l_set_evt));

    assert_rise_needs_read_r_R3: assert property (@(posedge clk_r) disable iff (rst_r)
        ($rose(r_irq_n) && !$past(rst_r)) |-> $past(r_release));
    assert_rise_needs_read_l_R5: assert property (@(posedge clk_l) disable iff (rst_l)
        ($rose(l_irq_n) && !$past(rst_l)) |-> $past(l_release));
endmodule

bind mbx_doorbell mbx_irq_checker #(.ADDR_W(ADDR_W)) u_irq_chk (.*);

// File: tb/mbx_doorbell_test.sv
module mbx_doorbell_test;
    localparam int AW = 18;
    localparam logic [AW-1:0] TOP  = '1;
    localparam logic [AW-1:0] NEXT = TOP - 1'b1;

    logic clk_l = 1'b0;
    logic clk_r = 1'b0;
    logic rst_l = 1'b1;
    logic rst_r = 1'b1;
    logic l_en = 1'b0, l_wr = 1'b0;
    logic r_en = 1'b0, r_wr = 1'b0;
    logic [AW-1:0] l_addr = '0;
    logic [AW-1:0] r_addr = '0;
    logic l_irq_n, r_irq_n;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    bit exp_l = 1'b1;
    bit exp_r = 1'b1;

    always #2 clk_r = ~clk_r;   // 250 MHz
    always #5 clk_l = ~clk_l;

    mbx_doorbell #(.ADDR_W(AW), .SYNC_STAGES(4)) uut (
        .clk_l(clk_l), .rst_l(rst_l), .l_en(l_en), .l_wr(l_wr), .l_addr(l_addr), .l_irq_n(l_irq_n),
        .clk_r(clk_r), .rst_r(rst_r), .r_en(r_en), .r_wr(r_wr), .r_addr(r_addr), .r_irq_n(r_irq_n)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string tag_of(input bit side, input bit en, input bit wr,
                                     input logic [AW-1:0] a);
        if (!en) return "R6";
        if (wr && side == 1'b0 && a == TOP)  return "R2";
        if (wr && side == 1'b1 && a == NEXT) return "R4";
        if (!wr && side == 1'b1 && a == TOP)  return "R3";
        if (!wr && side == 1'b0 && a == NEXT) return "R5";
        return "R7";
    endfunction

    function automatic void model(input bit side, input bit en, input bit wr,
                                  input logic [AW-1:0] a);
        if (!en) return;
        if (side == 1'b0) begin
            if (wr && a == TOP)   exp_r = 1'b0;
            if (!wr && a == NEXT) exp_l = 1'b1;
        end else begin
            if (wr && a == NEXT)  exp_l = 1'b0;
            if (!wr && a == TOP)  exp_r = 1'b1;
        end
    endfunction

    task automatic op_l(input bit en, input bit wr, input logic [AW-1:0] a);
        @(negedge clk_l);
        l_en = en; l_wr = wr; l_addr = a;
        @(negedge clk_l);
        l_en = 1'b0;
    endtask

    task automatic op_r(input bit en, input bit wr, input logic [AW-1:0] a);
        @(negedge clk_r);
        r_en = en; r_wr = wr; r_addr = a;
        @(negedge clk_r);
        r_en = 1'b0;
    endtask

    task automatic settle();
        repeat (30) @(negedge clk_l);
    endtask

    task automatic apply(input bit side, input bit en, input bit wr, input logic [AW-1:0] a);
        string t;
        t = tag_of(side, en, wr, a);
        model(side, en, wr, a);
        if (side) op_r(en, wr, a); else op_l(en, wr, a);
        settle();
        check({t, " left flag"},  l_irq_n, exp_l);
        check({t, " right flag"}, r_irq_n, exp_r);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        bit seen_low;
        void'($urandom(32'd4242));
        repeat (6) @(negedge clk_l);
        rst_l = 1'b0; rst_r = 1'b0;
        @(negedge clk_l);
        check("R1 reset left idle", l_irq_n, 1'b1);
        check("R1 reset right idle", r_irq_n, 1'b1);

        // directed basics
        apply(1'b0, 1'b1, 1'b1, TOP);    // R2
        apply(1'b0, 1'b1, 1'b0, TOP);    // R7 wrong side read
        apply(1'b1, 1'b1, 1'b0, TOP);    // R3
        apply(1'b1, 1'b1, 1'b1, NEXT);   // R4
        apply(1'b1, 1'b1, 1'b1, TOP);    // R7 write own box
        apply(1'b0, 1'b0, 1'b0, NEXT);   // R6 disabled read
        apply(1'b0, 1'b1, 1'b0, NEXT);   // R5
        apply(1'b1, 1'b0, 1'b1, NEXT);   // R6 disabled write

        // R8: right keeps reading its mailbox while left rings it
        seen_low = 1'b0;
        fork
            begin
                @(negedge clk_r);
                r_en = 1'b1; r_wr = 1'b0; r_addr = TOP;
                repeat (60) begin
                    @(negedge clk_r);
                    if (!r_irq_n) seen_low = 1'b1;
                end
                r_en = 1'b0;
            end
            begin
                repeat (2) @(negedge clk_l);
                op_l(1'b1, 1'b1, TOP);
            end
        join
        settle();
        check("R8 ring wins over same-edge release", seen_low, 1'b1);
        check("R8 flag released after read window", r_irq_n, 1'b1);
        exp_r = 1'b1;

        // R9: second ring while first still unacknowledged
        op_l(1'b1, 1'b1, TOP);
        for (int k = 0; k < 200 && r_irq_n; k++) @(negedge clk_r);
        check("R9 first ring arrived", r_irq_n, 1'b0);
        fork
            op_r(1'b1, 1'b0, TOP);
            op_l(1'b1, 1'b1, TOP);
        join
        settle();
        check("R9 retained ring lowers flag again", r_irq_n, 1'b0);
        exp_r = 1'b0;
        apply(1'b1, 1'b1, 1'b0, TOP);    // R3 release

        // constrained random traffic
        for (int i = 0; i < 150; i++) begin
            bit side, en, wr;
            logic [AW-1:0] a;
            side = 1'($urandom % 2);
            en   = (($urandom % 8) != 0);
            wr   = 1'($urandom % 2);
            case ($urandom % 4)
                0: a = TOP;
                1: a = NEXT;
                2: a = TOP - 2'd2;
                default: a = AW'($urandom);
            endcase
            apply(side, en, wr, a);
        end

        // R1: reset while both flags raised
        apply(1'b0, 1'b1, 1'b1, TOP);
        apply(1'b1, 1'b1, 1'b1, NEXT);
        rst_l = 1'b1; rst_r = 1'b1;
        repeat (3) @(negedge clk_l);
        check("R1 reset clears left", l_irq_n, 1'b1);
        check("R1 reset clears right", r_irq_n, 1'b1);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule